// File: doc/BRIEF.md
# Watchdog Timer with Keyed Refresh

A register-mapped supervisory timer. Software loads a timeout constant, turns the timer on, and must then keep refreshing it with a two-write key sequence to a dedicated refresh register. The countdown is clocked by a tick at half the input clock rate. If the countdown reaches zero, the block latches a timeout status bit and a sticky interrupt bit, and it drives the interrupt output. When the reset-on-timeout option is chosen, it also emits a fixed-length system reset request.

A refresh sequence that starts with the correct first key but is followed by any other value is treated as a software failure. The reset request then fires at once, whatever the count is. Once the timer is turned on, software cannot turn it off; only the block reset input returns it to the idle state.

The register bus is a plain single-cycle port. Every access completes in the cycle it is presented, and the block never applies back-pressure. Read data is combinational while the read strobe is high and zero otherwise. The interrupt and reset request pins are plain level outputs.

Top module: `wdt_feedguard`

## Requirements
- R1: After reset the control register reads 0, the constant register reads 0xFF, the count register reads 0, and the interrupt and reset request outputs are low.
- R2: Control register (byte address 0x0): bit 0 = run enable, bit 1 = reset-on-timeout, bit 2 = timeout status, bit 3 = interrupt status. Writing 1 to bit 0 sets the run enable; writing 0 never clears it.
- R3: The timeout status is set by a countdown expiry. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R4: The interrupt status is set by expiry and is not changed by any register write; the interrupt output equals it.
- R5: A write to the constant register (0x4) below 0xFF stores 0xFF; other values are stored as written.
- R6: A valid refresh writes low byte 0xAA and then low byte 0x55 to the refresh register (0x8). It loads the count from the constant, but only while run enable is set. Before the first such refresh the count stays at 0.
- R7: While running, the count (read at 0xC) drops by one every 2 clock cycles. The first decrement comes on the second clock edge after the refresh edge.
- R8: A refresh-register write whose low byte is not 0x55, directly following a 0xAA write, raises the reset request from the next edge for exactly 16 cycles.
- R9: When the count steps from 1 to 0, both status bits set on that edge and the interrupt output rises. The count then holds at 0 until the next valid refresh.
- R10: On expiry, the 16-cycle reset request is raised only if reset-on-timeout is 1.
- R11: A refresh-register write that does not follow a 0xAA write and is not itself 0xAA has no effect: the count and the reset request stay unchanged.
- R12: Reads of the refresh register return 0. Only word-aligned addresses 0x0, 0x4, 0x8 and 0xC are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| irq_o | output | 1 | Timeout interrupt, level |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The assertions assume the bus issues at most one access per cycle, with the strobes low during reset. They also assume the constant is never below the floor, so the count starts from a value of at least 0xFF and expiry is always a 1-to-0 step. The stimulus keeps to this by driving a single write or read per task call, with the strobes set just after the falling edge. Countdown expectations are computed by counting the rising edges that each bench task consumes after the refresh edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CONST = 2'd1,
    SEL_FEED  = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int B_EN   = 0;
  localparam int B_RSTE = 1;
  localparam int B_TOF  = 2;
  localparam int B_INT  = 3;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (restart || !run) phase_q <= '0;
    else if (tick)            phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feed_wr,
  input  logic [7:0] feed_byte,
  output logic       feed_ok,
  output logic       feed_bad
);
  logic armed_q;

  assign feed_ok  = feed_wr && armed_q && (feed_byte == KEY_SECOND);
  assign feed_bad = feed_wr && armed_q && (feed_byte != KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (feed_wr)  armed_q <= !armed_q && (feed_byte == KEY_FIRST);
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;

  assign pulse = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (trig)  left_q <= CW'(LEN);
    else if (pulse) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_feedguard.sv
module wdt_feedguard
  import wdt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int MIN_CONST = 255,
  parameter int PRESCALE  = 2,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = DATA_W;
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CONST);

  logic             addr_ok;
  reg_sel_e         sel;
  logic             wr_ctrl, wr_const, wr_feed;
  logic             en_q, rst_en_q, tof_q, intf_q;
  logic [CNT_W-1:0] const_q, cnt_q;
  logic             running_q;
  logic             feed_ok, feed_bad, reload, tick, expire;

  assign addr_ok  = ((bus_addr >> 4) == '0) && (bus_addr[1:0] == 2'b00);
  assign sel      = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl  = bus_wr && addr_ok && (sel == SEL_CTRL);
  assign wr_const = bus_wr && addr_ok && (sel == SEL_CONST);
  assign wr_feed  = bus_wr && addr_ok && (sel == SEL_FEED);

  wdt_feed_seq u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .feed_wr  (wr_feed),
    .feed_byte(bus_wdata[7:0]),
    .feed_ok  (feed_ok),
    .feed_bad (feed_bad)
  );

  assign reload = feed_ok && en_q;

  wdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (running_q),
    .restart(reload),
    .tick   (tick)
  );

  assign expire = tick && (cnt_q == CNT_W'(1));

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (feed_bad || (expire && rst_en_q)),
    .pulse(rst_req_o)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      tof_q    <= 1'b0;
      intf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= en_q | bus_wdata[B_EN];
        rst_en_q <= bus_wdata[B_RSTE];
      end
      if (expire)                         tof_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[B_TOF]) tof_q <= 1'b0;
      if (expire) intf_q <= 1'b1;
    end
  end

  // timeout constant with floor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        const_q <= FLOOR;
    else if (wr_const) const_q <= (bus_wdata < FLOOR) ? FLOOR : bus_wdata;
  end

  // countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (reload) begin
      cnt_q     <= const_q;
      running_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
      if (expire) running_q <= 1'b0;
    end
  end

  assign irq_o = intf_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && addr_ok) begin
      unique case (sel)
        SEL_CTRL:  bus_rdata = {{(DATA_W-4){1'b0}}, intf_q, tof_q, rst_en_q, en_q};
        SEL_CONST: bus_rdata = const_q;
        SEL_FEED:  bus_rdata = '0;
        SEL_COUNT: bus_rdata = cnt_q;
      endcase
    end
  end
endmodule

module wdt_feedguard_chk #(
  parameter int CNT_W     = 32,
  parameter int MIN_CONST = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             rst_en_q,
  input logic             intf_q,
  input logic [CNT_W-1:0] const_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             running_q,
  input logic             reload,
  input logic             expire,
  input logic             irq_o,
  input logic             rst_req_o
);
  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);
  // R4
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) intf_q |=> intf_q);
  // R5
  const_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) const_q >= CNT_W'(MIN_CONST));
  // R6
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) running_q |-> en_q);
  // R7
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !reload) |=> (cnt_q <= $past(cnt_q)));
  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !reload) |=> $stable(cnt_q));
  // R9
  irq_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n) expire |=> irq_o);
  // R10
  timeout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rst_en_q) |=> rst_req_o);
endmodule

bind wdt_feedguard wdt_feedguard_chk #(.CNT_W(CNT_W), .MIN_CONST(MIN_CONST)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_q     (en_q),
  .rst_en_q (rst_en_q),
  .intf_q   (intf_q),
  .const_q  (const_q),
  .cnt_q    (cnt_q),
  .running_q(running_q),
  .reload   (reload),
  .expire   (expire),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o)
);

// File: tb/sim_wdt_feedguard.sv
`timescale 1ns/1ps
module sim_wdt_feedguard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wdt_feedguard u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected value, the monitor compares it
  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pin(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    pin(irq_o, 1'b0, "R1 irq");
    pin(rst_req_o, 1'b0, "R1 rst_req");
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h4, 32'hFF, "R1 const");
    rd(4'hC, 32'h0, "R1 count");
    rd(4'h8, 32'h0, "R12 feed reads zero");
    // R5 floor
    wr(4'h4, 32'h10);
    rd(4'h4, 32'hFF, "R5 clamp");
    wr(4'h4, 32'h300);
    rd(4'h4, 32'h300, "R5 store");
    // R6 no reload while disabled
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    rd(4'hC, 32'h0, "R6 disabled feed");
    // R2 sticky enable
    wr(4'h0, 32'h1);
    rd(4'h0, 32'h1, "R2 enable set");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h1, "R2 enable sticky");
    // R11 stray writes ignored
    wr(4'h8, 32'h12); wr(4'h8, 32'h55);
    rd(4'hC, 32'h0, "R11 count");
    pin(rst_req_o, 1'b0, "R11 rst_req");
    // R6/R7 reload and countdown
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    idle(10);
    rd(4'hC, 32'h300 - 5, "R7 after 10 edges");
    idle(1);
    rd(4'hC, 32'h300 - 6, "R7 after 12 edges");
    // R9 expiry without reset
    wr(4'h4, 32'h100);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    rd(4'hC, 32'h100, "R6 reload value");
    idle(510);
    rd(4'hC, 32'h1, "R9 one before expiry");
    pin(irq_o, 1'b1, "R9 irq");
    pin(rst_req_o, 1'b0, "R10 no reset when disabled");
    rd(4'hC, 32'h0, "R9 count zero");
    rd(4'h0, 32'hD, "R9 flags");
    idle(20);
    rd(4'hC, 32'h0, "R9 held at zero");
    // R3/R4 flag writes
    wr(4'h0, 32'h1);
    rd(4'h0, 32'h9, "R3 clear tof R4 keep int");
    wr(4'h0, 32'h5);
    rd(4'h0, 32'h9, "R3 one leaves tof");
    pin(irq_o, 1'b1, "R4 irq stays");
    // R10 expiry with reset request
    wr(4'h0, 32'h3);
    wr(4'h4, 32'h10);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    rd(4'hC, 32'hFF, "R6 reload after expiry");
    idle(508);
    pin(rst_req_o, 1'b0, "R10 before expiry");
    idle(1);
    pin(rst_req_o, 1'b1, "R10 pulse start");
    idle(15);
    pin(rst_req_o, 1'b1, "R10 pulse end");
    idle(1);
    pin(rst_req_o, 1'b0, "R10 pulse over");
    // R8 wrong second key
    wr(4'h8, 32'hAA); wr(4'h8, 32'h77);
    pin(rst_req_o, 1'b1, "R8 immediate");
    idle(15);
    pin(rst_req_o, 1'b1, "R8 16th cycle");
    idle(1);
    pin(rst_req_o, 1'b0, "R8 released");
    idle(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule